// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address and the updated base value for a single-register load or store. It takes a base value, an offset, and the indexing controls of the transfer. The offset is either an immediate from the instruction or a register value. For the word/byte class, a register offset can first pass through a shifter. The result is combinational. The core's execute stage reads the access address, and it writes the updated base back to the register file when the write-back enable is high.

Two transfer classes exist. The word/byte class takes a 12-bit unsigned immediate or a shifted register. The halfword/signed class takes an 8-bit immediate built from two nibbles, or an unshifted register. A legality output flags the two forbidden uses of the program counter: as a written-back base, and as the register offset.

Top module: `lsu_addr_gen`

## Requirements
- R1: In the word/byte class (`half_cls`=0) with `use_imm`=1, the offset is `imm_field[11:0]` zero-extended, giving 0 to 4095.
- R2: In the word/byte class with `use_imm`=0, the offset is `roff_val` shifted by `sh_amt`. The `sh_kind` codes are 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right. An amount of 0 leaves the value unchanged for every kind.
- R3: With `up_dir`=1 the offset is added to the base. With `up_dir`=0 it is subtracted.
- R4: With `pre_idx`=1 the access address is base ± offset, and write-back is wanted only when `wb_req`=1.
- R5: With `pre_idx`=0 the access address is the unmodified base, and write-back is always wanted, whatever `wb_req` is.
- R6: In the halfword/signed class (`half_cls`=1) with `use_imm`=1, the offset is `{imm_field[11:8], imm_field[3:0]}` zero-extended (0 to 255). Bits 7:4 of `imm_field` have no effect.
- R7: In the halfword/signed class with `use_imm`=0, the offset is `roff_val` unshifted. `sh_kind` and `sh_amt` have no effect.
- R8: `bad_combo` is 1 when `base_is_pc`=1 and write-back is wanted, whether it was requested in pre-index mode or implied by post-index mode.
- R9: `bad_combo` is 1 when `use_imm`=0 and `roff_is_pc`=1. `roff_is_pc` has no effect when `use_imm`=1.
- R10: When `bad_combo` is 1, `wb_en` is 0. Otherwise `wb_en` equals the wanted write-back.
- R11: `new_base` is always base ± offset modulo 2^32, independent of `pre_idx` and `wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| use_imm | input | 1 | 1: immediate offset, 0: register offset |
| imm_field | input | 12 | Immediate offset field |
| roff_val | input | 32 | Register offset value |
| roff_is_pc | input | 1 | Offset register is the program counter |
| sh_kind | input | 2 | Shift type for a word/byte register offset |
| sh_amt | input | 5 | Shift amount |
| up_dir | input | 1 | 1 add, 0 subtract |
| pre_idx | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Write-back requested (pre-index) |
| half_cls | input | 1 | 1 halfword/signed class, 0 word/byte class |
| acc_addr | output | 32 | Access address |
| new_base | output | 32 | Updated base value |
| wb_en | output | 1 | Base write-back enable |
| bad_combo | output | 1 | Illegal combination flag |

## Verification
The hardest corner is the interaction of implied write-back with a program-counter base. A post-indexed transfer with `wb_req` low must still be flagged, and its write-back must be suppressed. The bench drives that case explicitly next to a pre-indexed one with write-back off. Rotate and arithmetic-right shifts are driven with sign-bit-set values and at amounts 0 and 31, where wrap errors show up. The nibble immediate is driven with bits 7:4 set, so that a wrong field pick shows in the address.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/lsu_offset_sel.sv
module lsu_offset_sel
  import lsu_agu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMMW  = 12,
  parameter int NIBW  = 4,
  parameter int SHW   = 5
) (
  input  logic [IMMW-1:0] imm_field,
  input  logic [DW-1:0]   roff_val,
  input  logic            use_imm,
  input  logic            half_cls,
  input  logic [1:0]      sh_kind,
  input  logic [SHW-1:0]  sh_amt,
  output logic [DW-1:0]   offset
);
  localparam int HALFW = 2 * NIBW;

  function automatic logic [DW-1:0] shift_val(input logic [DW-1:0] v,
                                              input logic [1:0] k,
                                              input logic [SHW-1:0] n);
    logic [DW-1:0] r;
    case (sh_kind_e'(k))
      SH_LSL: r = v << n;
      SH_LSR: r = v >> n;
      SH_ASR: r = DW'($signed(v) >>> n);
      default: r = (n == '0) ? v : ((v >> n) | (v << (DW - int'(n))));
    endcase
    return r;
  endfunction

  logic [DW-1:0] word_imm, half_imm, word_reg;

  assign word_imm = DW'(imm_field);
  assign half_imm = DW'({imm_field[IMMW-1 -: NIBW], imm_field[NIBW-1:0]});
  assign word_reg = shift_val(roff_val, sh_kind, sh_amt);

  always_comb begin
    if (use_imm) offset = half_cls ? half_imm : word_imm;
    else         offset = half_cls ? roff_val : word_reg;
  end

  logic unused_ok;
  assign unused_ok = ^HALFW;
endmodule

// File: rtl/lsu_index_calc.sv
module lsu_index_calc #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] offset,
  input  logic          up_dir,
  input  logic          pre_idx,
  input  logic          wb_req,
  output logic [DW-1:0] acc_addr,
  output logic [DW-1:0] new_base,
  output logic          wb_want
);
  function automatic logic [DW-1:0] apply_off(input logic [DW-1:0] b,
                                              input logic [DW-1:0] o,
                                              input logic up);
    return up ? (b + o) : (b - o);
  endfunction

  assign new_base = apply_off(base_val, offset, up_dir);
  assign acc_addr = pre_idx ? new_base : base_val;
  assign wb_want  = pre_idx ? wb_req : 1'b1;
endmodule

// File: rtl/lsu_legality.sv
module lsu_legality (
  input  logic wb_want,
  input  logic base_is_pc,
  input  logic use_imm,
  input  logic roff_is_pc,
  output logic pc_wb_err,
  output logic pc_off_err,
  output logic bad_combo,
  output logic wb_en
);
  assign pc_wb_err  = base_is_pc & wb_want;
  assign pc_off_err = ~use_imm & roff_is_pc;
  assign bad_combo  = pc_wb_err | pc_off_err;
  assign wb_en      = wb_want & ~bad_combo;
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int DW   = 32,
  parameter int IMMW = 12,
  parameter int NIBW = 4,
  parameter int SHW  = 5
) (
  input  logic [DW-1:0]   base_val,
  input  logic            base_is_pc,
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm_field,
  input  logic [DW-1:0]   roff_val,
  input  logic            roff_is_pc,
  input  logic [1:0]      sh_kind,
  input  logic [SHW-1:0]  sh_amt,
  input  logic            up_dir,
  input  logic            pre_idx,
  input  logic            wb_req,
  input  logic            half_cls,
  output logic [DW-1:0]   acc_addr,
  output logic [DW-1:0]   new_base,
  output logic            wb_en,
  output logic            bad_combo
);
  logic [DW-1:0] offset;
  logic          wb_want;
  logic          pc_wb_err;
  logic          pc_off_err;

  lsu_offset_sel #(.DW(DW), .IMMW(IMMW), .NIBW(NIBW), .SHW(SHW)) u_off (
    .imm_field(imm_field), .roff_val(roff_val), .use_imm(use_imm),
    .half_cls(half_cls), .sh_kind(sh_kind), .sh_amt(sh_amt), .offset(offset)
  );

  lsu_index_calc #(.DW(DW)) u_idx (
    .base_val(base_val), .offset(offset), .up_dir(up_dir), .pre_idx(pre_idx),
    .wb_req(wb_req), .acc_addr(acc_addr), .new_base(new_base), .wb_want(wb_want)
  );

  lsu_legality u_leg (
    .wb_want(wb_want), .base_is_pc(base_is_pc), .use_imm(use_imm),
    .roff_is_pc(roff_is_pc), .pc_wb_err(pc_wb_err), .pc_off_err(pc_off_err),
    .bad_combo(bad_combo), .wb_en(wb_en)
  );
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0] base_val,
  input logic          base_is_pc,
  input logic          pre_idx,
  input logic          wb_req,
  input logic          up_dir,
  input logic          use_imm,
  input logic          half_cls,
  input logic [DW-1:0] acc_addr,
  input logic [DW-1:0] new_base,
  input logic          wb_en,
  input logic          bad_combo,
  input logic          wb_want,
  input logic          pc_wb_err
);
  logic [DW-1:0] delta;
  assign delta = up_dir ? (new_base - base_val) : (base_val - new_base);

  always_comb begin
    if (!pre_idx)
      a_r5_post_uses_base: assert (acc_addr == base_val);
    if (pre_idx)
      a_r4_pre_uses_sum: assert (acc_addr == new_base);
    if (!pre_idx)
      a_r5_post_implies_wb: assert (wb_want);
    if (pre_idx)
      a_r4_pre_follows_req: assert (wb_want == wb_req);
    if (base_is_pc && !pre_idx)
      a_r8_pc_post_flagged: assert (bad_combo && pc_wb_err);
    if (bad_combo)
      a_r10_no_wb_on_err: assert (!wb_en);
    if (half_cls && use_imm)
      a_r6_half_imm_range: assert (delta <= DW'(255));
  end
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.DW(DW)) u_chk (
  .base_val(base_val), .base_is_pc(base_is_pc), .pre_idx(pre_idx),
  .wb_req(wb_req), .up_dir(up_dir), .use_imm(use_imm), .half_cls(half_cls),
  .acc_addr(acc_addr), .new_base(new_base), .wb_en(wb_en),
  .bad_combo(bad_combo), .wb_want(wb_want), .pc_wb_err(pc_wb_err)
);

// File: tb/lsu_addr_gen_tb_top.sv
module lsu_addr_gen_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] base_val, roff_val, acc_addr, new_base;
  logic        base_is_pc, use_imm, roff_is_pc, up_dir, pre_idx, wb_req, half_cls;
  logic [11:0] imm_field;
  logic [1:0]  sh_kind;
  logic [4:0]  sh_amt;
  logic        wb_en, bad_combo;

  int total = 0;
  int bad   = 0;

  lsu_addr_gen dut_i (
    .base_val(base_val), .base_is_pc(base_is_pc), .use_imm(use_imm),
    .imm_field(imm_field), .roff_val(roff_val), .roff_is_pc(roff_is_pc),
    .sh_kind(sh_kind), .sh_amt(sh_amt), .up_dir(up_dir), .pre_idx(pre_idx),
    .wb_req(wb_req), .half_cls(half_cls), .acc_addr(acc_addr),
    .new_base(new_base), .wb_en(wb_en), .bad_combo(bad_combo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_shift(input logic [31:0] v, input int k, input int n);
    logic [63:0] dbl;
    logic [31:0] r;
    r = v;
    case (k)
      0: for (int i = 0; i < n; i++) r = {r[30:0], 1'b0};
      1: for (int i = 0; i < n; i++) r = {1'b0, r[31:1]};
      2: for (int i = 0; i < n; i++) r = {r[31], r[31:1]};
      default: begin dbl = {v, v}; r = dbl[n +: 32]; end
    endcase
    return r;
  endfunction

  task automatic apply(input logic [31:0] b, input logic ui, input logic [11:0] imm,
                       input logic [31:0] ro, input logic [1:0] sk, input logic [4:0] sa,
                       input logic up, input logic pre, input logic wr, input logic hc,
                       input logic bpc, input logic rpc);
    @(negedge clk);
    base_val = b; use_imm = ui; imm_field = imm; roff_val = ro; sh_kind = sk;
    sh_amt = sa; up_dir = up; pre_idx = pre; wb_req = wr; half_cls = hc;
    base_is_pc = bpc; roff_is_pc = rpc;
    #2;
  endtask

  task automatic t_word_imm;
    apply(32'h0000_1000, 1, 12'hFFF, 32'h0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R1 imm max add addr", acc_addr, 32'h0000_1FFF);
    chk("R4 pre no wb", {31'b0, wb_en}, 32'd0);
    apply(32'h0000_1000, 1, 12'h00C, 32'h0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R3 sub addr", acc_addr, 32'h0000_0FF4);
    chk("R4 pre wb", {31'b0, wb_en}, 32'd1);
  endtask

  task automatic t_word_reg;
    for (int k = 0; k < 4; k++) begin
      apply(32'h0000_0200, 0, 12'h0, 32'h8000_00F3, k[1:0], 5'd4, 1, 1, 1, 0, 0, 0);
      chk("R2 shift amt4", acc_addr, 32'h200 + ref_shift(32'h8000_00F3, k, 4));
      apply(32'h0000_0200, 0, 12'h0, 32'h8000_00F3, k[1:0], 5'd31, 1, 1, 1, 0, 0, 0);
      chk("R2 shift amt31", acc_addr, 32'h200 + ref_shift(32'h8000_00F3, k, 31));
      apply(32'h0000_0200, 0, 12'h0, 32'h8000_00F3, k[1:0], 5'd0, 1, 1, 1, 0, 0, 0);
      chk("R2 shift amt0", acc_addr, 32'h8000_02F3);
    end
  endtask

  task automatic t_post;
    apply(32'h0000_0200, 1, 12'h00C, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 post addr", acc_addr, 32'h0000_0200);
    chk("R5 post new base", new_base, 32'h0000_01F4);
    chk("R5 implied wb", {31'b0, wb_en}, 32'd1);
    apply(32'h0000_0004, 1, 12'h008, 32'h0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R11 wrap new base", new_base, 32'hFFFF_FFFC);
    apply(32'hFFFF_FFF0, 1, 12'h020, 32'h0, 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R11 wrap add", new_base, 32'h0000_0010);
  endtask

  task automatic t_half;
    apply(32'h0000_1000, 1, 12'hAF5, 32'h0, 0, 0, 1, 1, 0, 1, 0, 0);
    chk("R6 nibble imm", acc_addr, 32'h0000_10A5);
    apply(32'h0000_1000, 0, 12'h0, 32'h0000_0011, 2'd0, 5'd3, 1, 1, 0, 1, 0, 0);
    chk("R7 reg unshifted", acc_addr, 32'h0000_1011);
  endtask

  task automatic t_legal;
    apply(32'h0000_0100, 1, 12'h004, 32'h0, 0, 0, 1, 0, 0, 0, 1, 0);
    chk("R8 pc post flag", {31'b0, bad_combo}, 32'd1);
    chk("R10 pc post wb off", {31'b0, wb_en}, 32'd0);
    apply(32'h0000_0100, 1, 12'h004, 32'h0, 0, 0, 1, 1, 0, 0, 1, 0);
    chk("R8 pc pre no wb ok", {31'b0, bad_combo}, 32'd0);
    apply(32'h0000_0100, 1, 12'h004, 32'h0, 0, 0, 1, 1, 1, 0, 1, 0);
    chk("R8 pc pre wb flag", {31'b0, bad_combo}, 32'd1);
    apply(32'h0000_0100, 0, 12'h0, 32'h4, 0, 0, 1, 1, 1, 0, 0, 1);
    chk("R9 pc offset flag", {31'b0, bad_combo}, 32'd1);
    chk("R10 wb suppressed", {31'b0, wb_en}, 32'd0);
    apply(32'h0000_0100, 1, 12'h004, 32'h0, 0, 0, 1, 1, 1, 0, 0, 1);
    chk("R9 ignored with imm", {31'b0, bad_combo}, 32'd0);
  endtask

  initial begin
    apply(32'h0, 1, 12'h0, 32'h0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R4 idle addr", acc_addr, 32'h0);
    chk("R10 idle flags", {30'b0, wb_en, bad_combo}, 32'd0);
    t_word_imm();
    t_word_reg();
    t_post();
    t_half();
    t_legal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule